// File: doc/BRIEF.md
# Dual Timer/Counter with Selectable Modes

The block holds two timer/counter channels. Each channel is built from a pair of byte registers, a low byte and a high byte. A shared 8-bit mode register sets up both channels. A 2-bit run register starts and stops them. A free-running divider produces one machine-cycle strobe every 12 core clocks (parameter `MC_DIV`). In timer function a channel advances once per strobe. In counter function it advances once per falling edge of its external count pin, where the pin is seen only through its once-per-machine-cycle samples.

An optional gate makes counting depend on a second external pin, the enable pin. Both external pins pass through a two-flop synchronizer before any use. Each channel offers four arrangements of its bytes: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads itself, and a split arrangement. In the split arrangement channel 0 becomes two independent 8-bit counters. Each counter that is in use sets a sticky overflow flag, and software clears a flag with a strobe. Software reads and writes every register one byte at a time on a single address bus.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset every register (mode, run, all four count bytes, flags) reads 0x00, and both `ovf` bits are 0.
- R2: Register addresses are: 0 mode, 1 run (bit 0 channel 0, bit 1 channel 1, upper bits read 0), 2 ch0 low, 3 ch0 high, 4 ch1 low, 5 ch1 high, 6 flags (bit 0, bit 1; read-only). In the mode byte, bits 7:4 configure channel 1 and bits 3:0 configure channel 0. Within each nibble the bits are, from MSB down: gate, counter select, mode[1], mode[0]. Mode and run read back exactly as written.
- R3: In timer function an enabled channel advances exactly once per machine cycle of 12 clocks, and not in between.
- R4: Mode 00: the high byte and the low 5 bits of the low byte form a 13-bit counter. Bits 7:5 of the low byte are untouched. The overflow flag is set when the counter wraps from 0x1FFF to 0.
- R5: Mode 01: the high and low bytes form one 16-bit counter. The overflow flag is set on the wrap from 0xFFFF to 0.
- R6: Mode 10: the low byte counts. When it would pass 0xFF, it is loaded with the high byte and the overflow flag is set. The high byte does not change.
- R7: Mode 11 on channel 0: the ch0 low byte counts as an 8-bit counter under channel 0's gate, select and run bit, and it sets flag bit 0. The ch0 high byte counts machine cycles whenever run bit 1 is set, and it sets flag bit 1.
- R8: Channel 1 holds its bytes while its own mode is 11. While channel 0 is in mode 11, channel 1 still counts, but its overflows do not set flag bit 1.
- R9: In counter function (select bit 1) the count pin is sampled once per machine cycle. A high sample followed by a low sample raises the count by one, one machine cycle after the low sample. A pin held low does not count again.
- R10: With the gate bit set, a channel counts only while its run bit is 1 and its enable pin is high. With the gate bit clear, the run bit alone decides.
- R11: Flags are sticky. A flag is cleared only by a 1 on its `flag_clr` bit (bit 0 for flag 0, bit 1 for flag 1). `ovf` shows the flags.
- R12: A write to any count byte of a channel takes effect in full, and that channel does no counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| flag_clr | input | 2 | Per-flag clear strobe |
| cnt_pin | input | 2 | External count inputs, one per channel |
| en_pin | input | 2 | External enable inputs for gated counting |
| ovf | output | 2 | Sticky overflow flags |

## Verification
The bench targets the wrap boundaries of each mode:

- **13-bit wrap:** a design that carried into bits 7:5 of the low byte would show a wrong low byte after the wrap.
- **Reload:** a design that reloaded one count late, or that changed the high byte, would end on a wrong low byte.
- **Split mode:** the bench checks that flag bit 1 follows the ch0 high byte and not a wrapping channel 1. A design that let channel 1 own flag 1 would raise it wrongly.
- **Counter function:** the bench times the one-machine-cycle delay of an edge count and holds the pin low for a long time. A design that counted levels or counted early would show the wrong value at the sampled tick.
- **Write priority:** the bench writes a count byte exactly on a machine-cycle edge. A design that let the increment win would show a moved count.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int BW    = 8;   // byte width of every register
    localparam int PRE_W = 5;   // prescaler bits of the low byte in mode 00
    localparam int NCH   = 2;
    localparam int AW    = 3;

    typedef enum logic [1:0] {
        MD_PRE13   = 2'b00,
        MD_CAS16   = 2'b01,
        MD_RELOAD8 = 2'b10,
        MD_SPLIT   = 2'b11
    } tmode_e;

    typedef struct packed {
        logic       gate;
        logic       ext;
        logic [1:0] md;
    } chcfg_t;

    typedef struct packed {
        chcfg_t [NCH-1:0]        cfg;
        logic   [NCH-1:0]        run;
        logic   [NCH-1:0][BW-1:0] lo;
        logic   [NCH-1:0][BW-1:0] hi;
        logic   [NCH-1:0]        flag;
    } regs_t;

    localparam logic [AW-1:0] A_MODE = 3'd0;
    localparam logic [AW-1:0] A_RUN  = 3'd1;
    localparam logic [AW-1:0] A_LO0  = 3'd2;
    localparam logic [AW-1:0] A_HI0  = 3'd3;
    localparam logic [AW-1:0] A_LO1  = 3'd4;
    localparam logic [AW-1:0] A_HI1  = 3'd5;
    localparam logic [AW-1:0] A_FLAG = 3'd6;
endpackage

// File: rtl/dmt_mc_tick.sv
module dmt_mc_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dmt_sync.sv
module dmt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
        dout = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/dmt_pin_edge.sv
module dmt_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall_pend
);
    logic lvl;
    logic samp_d, samp_q;
    logic pend_d, pend_q;

    dmt_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin),
        .dout (lvl)
    );

    // one sample per machine cycle; a high-then-low pair is held for one cycle
    always_comb begin
        samp_d    = samp_q;
        pend_d    = pend_q;
        if (tick) begin
            samp_d = lvl;
            pend_d = samp_q & ~lvl;
        end
        fall_pend = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            samp_q <= samp_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/dmt_step.sv
module dmt_step
    import dmt_pkg::*;
(
    input  logic [1:0]    md,
    input  logic [BW-1:0] lo,
    input  logic [BW-1:0] hi,
    input  logic          inc_a,
    input  logic          inc_b,
    output logic [BW-1:0] lo_n,
    output logic [BW-1:0] hi_n,
    output logic          ovf_a,
    output logic          ovf_b
);
    localparam int W13 = PRE_W + BW + 1;
    localparam int W16 = 2 * BW + 1;
    localparam int W8  = BW + 1;

    logic [W13-1:0] s13;
    logic [W16-1:0] s16;
    logic [W8-1:0]  sl, sh;

    always_comb begin
        s13   = {1'b0, hi, lo[PRE_W-1:0]} + W13'(1);
        s16   = {1'b0, hi, lo} + W16'(1);
        sl    = {1'b0, lo} + W8'(1);
        sh    = {1'b0, hi} + W8'(1);
        lo_n  = lo;
        hi_n  = hi;
        ovf_a = 1'b0;
        ovf_b = 1'b0;
        case (md)
            MD_PRE13: if (inc_a) begin
                ovf_a            = s13[W13-1];
                hi_n             = s13[W13-2:PRE_W];
                lo_n[PRE_W-1:0]  = s13[PRE_W-1:0];
            end
            MD_CAS16: if (inc_a) begin
                ovf_a = s16[W16-1];
                hi_n  = s16[W16-2:BW];
                lo_n  = s16[BW-1:0];
            end
            MD_RELOAD8: if (inc_a) begin
                ovf_a = sl[W8-1];
                lo_n  = sl[W8-1] ? hi : sl[BW-1:0];
            end
            default: begin
                if (inc_a) begin
                    ovf_a = sl[W8-1];
                    lo_n  = sl[BW-1:0];
                end
                if (inc_b) begin
                    ovf_b = sh[W8-1];
                    hi_n  = sh[BW-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter int MC_DIV      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wr_data,
    output logic [BW-1:0] rd_data,
    input  logic [NCH-1:0] flag_clr,
    input  logic [NCH-1:0] cnt_pin,
    input  logic [NCH-1:0] en_pin,
    output logic [NCH-1:0] ovf
);
    regs_t r_d, r_q;

    logic                    mc_tick;
    logic [NCH-1:0]          en_s;
    logic [NCH-1:0]          fall_p;
    logic [NCH-1:0]          inc_a, inc_b, ovf_a, ovf_b, hit, chan_en;
    logic [NCH-1:0][BW-1:0]  lo_n, hi_n;
    logic                    split0;

    dmt_mc_tick #(.DIV(MC_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (mc_tick)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dmt_pin_edge #(.STAGES(SYNC_STAGES)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (mc_tick),
                .pin      (cnt_pin[c]),
                .fall_pend(fall_p[c])
            );
            dmt_sync #(.STAGES(SYNC_STAGES)) u_en (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (en_pin[c]),
                .dout (en_s[c])
            );
            dmt_step u_step (
                .md   (r_q.cfg[c].md),
                .lo   (r_q.lo[c]),
                .hi   (r_q.hi[c]),
                .inc_a(inc_a[c]),
                .inc_b(inc_b[c]),
                .lo_n (lo_n[c]),
                .hi_n (hi_n[c]),
                .ovf_a(ovf_a[c]),
                .ovf_b(ovf_b[c])
            );
        end
    endgenerate

    // count qualification
    always_comb begin
        split0 = (r_q.cfg[0].md == MD_SPLIT);
        for (int c = 0; c < NCH; c++) begin
            chan_en[c] = r_q.run[c] & (~r_q.cfg[c].gate | en_s[c]);
            inc_a[c]   = mc_tick & chan_en[c] & (r_q.cfg[c].ext ? fall_p[c] : 1'b1);
        end
        inc_a[1] = inc_a[1] & (r_q.cfg[1].md != MD_SPLIT);
        inc_b[0] = split0 & mc_tick & r_q.run[1];
        inc_b[1] = 1'b0;
        hit[0]   = wr_en & ((addr == A_LO0) | (addr == A_HI0));
        hit[1]   = wr_en & ((addr == A_LO1) | (addr == A_HI1));
    end

    // next state
    always_comb begin
        logic [NCH-1:0] set_f;
        r_d = r_q;
        for (int c = 0; c < NCH; c++) begin
            if (!hit[c]) begin
                r_d.lo[c] = lo_n[c];
                r_d.hi[c] = hi_n[c];
            end
        end
        set_f[0] = ovf_a[0] & ~hit[0];
        set_f[1] = split0 ? (ovf_b[0] & ~hit[0]) : ((ovf_a[1] | ovf_b[1]) & ~hit[1]);
        r_d.flag = (r_q.flag & ~flag_clr) | set_f;
        if (wr_en) begin
            case (addr)
                A_MODE:  r_d.cfg   = wr_data;
                A_RUN:   r_d.run   = wr_data[NCH-1:0];
                A_LO0:   r_d.lo[0] = wr_data;
                A_HI0:   r_d.hi[0] = wr_data;
                A_LO1:   r_d.lo[1] = wr_data;
                A_HI1:   r_d.hi[1] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_MODE:  rd_data = r_q.cfg;
            A_RUN:   rd_data = {{(BW-NCH){1'b0}}, r_q.run};
            A_LO0:   rd_data = r_q.lo[0];
            A_HI0:   rd_data = r_q.hi[0];
            A_LO1:   rd_data = r_q.lo[1];
            A_HI1:   rd_data = r_q.hi[1];
            A_FLAG:  rd_data = {{(BW-NCH){1'b0}}, r_q.flag};
            default: rd_data = '0;
        endcase
        ovf = r_q.flag;
    end
endmodule

// File: rtl/dual_mode_timer_chk.sv
module dual_mode_timer_chk
    import dmt_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic [BW-1:0]  wr_data,
    input logic [NCH-1:0] flag_clr,
    input logic [NCH-1:0] ovf,
    input logic           tick,
    input logic [NCH-1:0] en_sync,
    input regs_t          st
);
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_MODE) |=> $stable(st.cfg)); // R2

    AST_NO_STEP_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(st.lo) && $stable(st.hi))); // R3

    AST_RUN_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st.run[0] && !wr_en) |=> $stable(st.lo[0])); // R10

    AST_GATE_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st.cfg[0].gate && !en_sync[0] && !wr_en) |=> $stable(st.lo[0])); // R10

    AST_CH1_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (st.cfg[1].md == MD_SPLIT && !wr_en) |=> ($stable(st.lo[1]) && $stable(st.hi[1]))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !flag_clr[0]) |=> ovf[0]); // R11

    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf[1]) |-> $past(tick)); // R11

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LO0) |=> (st.lo[0] == $past(wr_data))); // R12
endmodule

bind dual_mode_timer dual_mode_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .flag_clr(flag_clr),
    .ovf     (ovf),
    .tick    (mc_tick),
    .en_sync (en_s),
    .st      (r_q)
);

// File: tb/dual_mode_timer_tb.sv
`timescale 1ns/1ps
module dual_mode_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] flag_clr = '0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] en_pin = 2'b00;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;

    always #10 clk = ~clk;

    always @(posedge clk) edges <= !rst_n ? 0 : edges + 1;

    dual_mode_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .flag_clr(flag_clr),
        .cnt_pin(cnt_pin), .en_pin(en_pin), .ovf(ovf)
    );

    // {mode, lo, hi, ticks, exp lo, exp hi, exp flags}
    localparam logic [39:0] VEC [0:7] = '{
        {2'd1, 8'hFE, 8'h00, 4'd3,  8'h01, 8'h01, 2'b00},
        {2'd1, 8'hFF, 8'hFF, 4'd2,  8'h01, 8'h00, 2'b01},
        {2'd0, 8'h1E, 8'h05, 4'd3,  8'h01, 8'h06, 2'b00},
        {2'd0, 8'hFF, 8'hFF, 4'd1,  8'hE0, 8'h00, 2'b01},
        {2'd2, 8'hFE, 8'h80, 4'd3,  8'h81, 8'h80, 2'b01},
        {2'd2, 8'h10, 8'h20, 4'd4,  8'h14, 8'h20, 2'b00},
        {2'd3, 8'hFF, 8'h00, 4'd2,  8'h01, 8'h00, 2'b01},
        {2'd1, 8'hF0, 8'h12, 4'd15, 8'hFF, 8'h12, 2'b00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic clr(input logic [1:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = 2'b00;
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (edges % 12 != 0);
        end
    endtask

    task automatic setup0(input logic [7:0] mode, input logic [7:0] lo, input logic [7:0] hi);
        wr(3'd1, 8'h00);
        wr(3'd0, mode);
        wr(3'd2, lo);
        wr(3'd3, hi);
        clr(2'b11);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", edges);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1", {8'h00, v}, 16'h0000);
        end
        chk("R1 ovf", {14'd0, ovf}, 16'h0000);

        // R2 readback
        wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2 mode", {8'h0, v}, 16'h00A5);
        wr(3'd1, 8'hFE); rd(3'd1, v); chk("R2 run", {8'h0, v}, 16'h0002);
        wr(3'd1, 8'h00);

        // table walk: channel 0, run bit 0 only
        for (int i = 0; i < 8; i++) begin
            logic [1:0] md;
            logic [3:0] nt;
            string rq;
            md = VEC[i][39:38];
            nt = VEC[i][21:18];
            rq = (md == 2'd0) ? "R4" : (md == 2'd1) ? "R5" : (md == 2'd2) ? "R6" : "R7";
            setup0({6'd0, md}, VEC[i][37:30], VEC[i][29:22]);
            wait_ticks(1);
            wr(3'd1, 8'h01);
            wait_ticks(int'(nt));
            rd(3'd2, v);
            rd(3'd3, w);
            chk(rq, {w, v}, {VEC[i][9:2], VEC[i][17:10]});
            chk(rq, {14'd0, ovf}, {14'd0, VEC[i][1:0]});
        end

        // R3 exact rate
        setup0(8'h01, 8'h00, 8'h00);
        wr(3'd1, 8'h01);
        wait_ticks(1);
        rd(3'd2, v);
        repeat (11) @(negedge clk);
        rd(3'd2, w); chk("R3 hold", {8'h0, w}, {8'h0, v});
        @(negedge clk);
        rd(3'd2, w); chk("R3 step", {8'h0, w}, {8'h0, v + 8'd1});

        // R7/R8 split: ch0 mode 11, ch1 mode 01 wrapping
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h13);
        wr(3'd2, 8'hFE); wr(3'd3, 8'h10);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        clr(2'b11);
        wait_ticks(1);
        wr(3'd1, 8'h03);
        wait_ticks(3);
        rd(3'd2, v); chk("R7 lo0", {8'h0, v}, 16'h0001);
        rd(3'd3, v); chk("R7 hi0", {8'h0, v}, 16'h0013);
        rd(3'd4, v); rd(3'd5, w); chk("R8 ch1 runs", {w, v}, 16'h0002);
        chk("R8 flag1 owner", {14'd0, ovf}, 16'h0001);

        // R8 channel 1 halted in mode 11
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h31);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'h05); wr(3'd5, 8'h00);
        wait_ticks(1);
        wr(3'd1, 8'h03);
        wait_ticks(3);
        rd(3'd4, v); rd(3'd5, w); chk("R8 halt", {w, v}, 16'h0005);
        rd(3'd2, v); chk("R8 ch0", {8'h0, v}, 16'h0003);

        // R9 counter function
        setup0(8'h05, 8'h00, 8'h00);
        wr(3'd1, 8'h01);
        wait_ticks(2);
        cnt_pin[0] = 1'b0;
        wait_ticks(1);
        rd(3'd2, v); chk("R9 not yet", {8'h0, v}, 16'h0000);
        wait_ticks(1);
        rd(3'd2, v); chk("R9 counted", {8'h0, v}, 16'h0001);
        wait_ticks(3);
        rd(3'd2, v); chk("R9 low level", {8'h0, v}, 16'h0001);
        cnt_pin[0] = 1'b1;
        wait_ticks(2);
        rd(3'd2, v); chk("R9 rising", {8'h0, v}, 16'h0001);
        cnt_pin[0] = 1'b0;
        wait_ticks(2);
        rd(3'd2, v); chk("R9 second", {8'h0, v}, 16'h0002);
        cnt_pin[0] = 1'b1;

        // R10 gate
        setup0(8'h09, 8'h00, 8'h00);
        en_pin[0] = 1'b0;
        wr(3'd1, 8'h01);
        wait_ticks(3);
        rd(3'd2, v); chk("R10 gate closed", {8'h0, v}, 16'h0000);
        en_pin[0] = 1'b1;
        wait_ticks(3);
        rd(3'd2, v); chk("R10 gate open", {8'h0, v}, 16'h0003);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        wait_ticks(2);
        rd(3'd2, v); chk("R10 run off", {8'h0, v}, 16'h0003);
        en_pin[0] = 1'b0;

        // R12 write at a tick edge
        setup0(8'h01, 8'h10, 8'h00);
        wr(3'd1, 8'h01);
        wait_ticks(1);
        rd(3'd2, v);
        repeat (11) @(negedge clk);
        wr(3'd3, 8'h55);
        rd(3'd2, w); chk("R12 lo held", {8'h0, w}, {8'h0, v});
        rd(3'd3, w); chk("R12 hi written", {8'h0, w}, 16'h0055);
        wait_ticks(1);
        rd(3'd2, w); chk("R12 resumes", {8'h0, w}, {8'h0, v + 8'd1});

        // R11 sticky flags and clear strobe
        setup0(8'h01, 8'hFF, 8'hFF);
        wr(3'd1, 8'h01);
        wait_ticks(1);
        chk("R11 set", {14'd0, ovf}, 16'h0001);
        wait_ticks(2);
        rd(3'd6, v); chk("R11 sticky", {8'h0, v}, 16'h0001);
        clr(2'b10);
        chk("R11 other bit", {14'd0, ovf}, 16'h0001);
        clr(2'b01);
        chk("R11 cleared", {14'd0, ovf}, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule